// File: doc/BRIEF.md
# Wake-Up and Halt Control Register

This block is one 8-bit control register that manages the low-power behaviour of a USB device node. Software sets up per-source wake enables, picks whether the wake-up interrupt fires at once or after a programmable delay, and asks for halt in one of two ways. With halt-on-suspend set, the node halts when it goes into suspend. With force-halt, the node halts at once, but only while it is detached from the bus.

While the node is halted, an enabled wake source ends the halt. The two sources are a USB bus-activity pulse and a local processor-access pulse. The source's pending flag is set, and that flag requests the wake-up interrupt. Both pending flags come out of reset set. Software clears a flag by writing 0 to its bit. Writing 1 to a pending bit does nothing.

Reads return the register image while the read strobe is high and zero otherwise. Suspend-state detection and clock gating live outside this block.

Top module: `wkp_ctrl`

## Requirements
- R1: After synchronous reset the register reads 0x0F, `halted` is 0 and `wake_irq` is 1. Bits 7, 6 and 5 are 0, the enables (bits 3, 2) are 1 and the pending flags (bits 1, 0) are 1.
- R2: A write with bit 0 (USB pending) or bit 1 (processor pending) at 0 clears that flag. A write with the bit at 1 leaves the flag unchanged.
- R3: A wake pulse whose enable (bit 2 for USB, bit 3 for processor) is 0 leaves `halted` and both pending flags unchanged.
- R4: While `halted` is 1, a wake pulse whose enable is set makes `halted` 0 at the next clock edge. At the same edge it sets the matching pending flag.
- R5: While `halted` is 0, wake pulses have no effect on the pending flags.
- R6: With mode bit 5 at 0, `wake_irq` equals the OR of the two pending flags in the same cycle.
- R7: With mode bit 5 at 1, a wake pulse starts a count of DELAY clocks. `wake_irq` stays 0 until DELAY clocks after the pending flag is set, and then follows the pending flags.
- R8: With halt-on-suspend bit 6 at 1, a 0-to-1 change of `suspend` makes `halted` 1 at the next clock edge.
- R9: A write of 1 to bit 6 while `suspend` is 1 is ignored. A write of 0 to bit 6 is always accepted.
- R10: A write of 1 to force-halt bit 7 while `attached` is 0 sets bit 7 and makes `halted` 1 at the next edge. While `attached` is 1, that write is ignored.
- R11: Bit 4 always reads 0, whatever was written.
- R12: `rd_data` is 0 whenever `rd_en` is 0.
- R13: Leaving halt through a wake pulse clears force-halt bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Register image while reading, else 0 |
| usb_evt | input | 1 | USB bus activity pulse |
| uc_evt | input | 1 | Local processor access pulse |
| suspend | input | 1 | Node is in suspend state |
| attached | input | 1 | Node is attached to the bus |
| halted | output | 1 | Node is in halt |
| wake_irq | output | 1 | Wake-up interrupt request |

## Verification
The bench builds the block with DELAY set to 8 instead of 1024. This brings the end of the delayed-interrupt window within a few cycles, so one run can observe the exact edge at which a delayed interrupt rises, and random stimulus can restart the delay window many times. Directed steps cover each ignored-write rule at the bit level. A random phase then mixes writes, suspend edges and attach changes, and every cycle is compared against the behavioural model.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

    localparam int REG_W     = 8;
    localparam int B_FHALT   = 7;
    localparam int B_HOS     = 6;
    localparam int B_MODE    = 5;
    localparam int B_RSV     = 4;
    localparam int B_EN_UC   = 3;
    localparam int B_EN_USB  = 2;
    localparam int B_PND_UC  = 1;
    localparam int B_PND_USB = 0;

    typedef struct packed {
        logic force_halt;
        logic halt_on_susp;
        logic delayed_irq;
        logic en_uc;
        logic en_usb;
        logic pend_uc;
        logic pend_usb;
    } wkp_fields_t;

    typedef struct packed {
        logic usb;
        logic uc;
    } wkp_src_t;

    localparam wkp_fields_t WKP_RESET = '{
        force_halt:   1'b0,
        halt_on_susp: 1'b0,
        delayed_irq:  1'b0,
        en_uc:        1'b1,
        en_usb:       1'b1,
        pend_uc:      1'b1,
        pend_usb:     1'b1
    };

    function automatic logic [REG_W-1:0] wkp_pack(input wkp_fields_t f);
        logic [REG_W-1:0] v;
        v            = '0;
        v[B_FHALT]   = f.force_halt;
        v[B_HOS]     = f.halt_on_susp;
        v[B_MODE]    = f.delayed_irq;
        v[B_EN_UC]   = f.en_uc;
        v[B_EN_USB]  = f.en_usb;
        v[B_PND_UC]  = f.pend_uc;
        v[B_PND_USB] = f.pend_usb;
        return v;
    endfunction

endpackage

// File: rtl/wkp_regs.sv
module wkp_regs
    import wkp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             suspend,
    input  logic             attached,
    input  wkp_src_t         wake,
    input  logic             halted,
    output wkp_fields_t      fields,
    output logic             fh_set
);

    wkp_fields_t f_q, f_d;
    logic        wake_any;
    logic        unused_rsv;

    assign unused_rsv = wr_data[B_RSV];
    assign wake_any   = wake.usb | wake.uc;
    assign fh_set     = wr_en & wr_data[B_FHALT] & ~attached;

    always_comb begin
        f_d = f_q;
        if (wr_en) begin
            f_d.delayed_irq = wr_data[B_MODE];
            f_d.en_uc       = wr_data[B_EN_UC];
            f_d.en_usb      = wr_data[B_EN_USB];
            if (!(wr_data[B_HOS] && suspend))
                f_d.halt_on_susp = wr_data[B_HOS];
            if (!wr_data[B_FHALT])
                f_d.force_halt = 1'b0;
            else if (!attached)
                f_d.force_halt = 1'b1;
            if (!wr_data[B_PND_UC])
                f_d.pend_uc = 1'b0;
            if (!wr_data[B_PND_USB])
                f_d.pend_usb = 1'b0;
        end
        if (wake_any)
            f_d.force_halt = 1'b0;
        if (wake.uc)
            f_d.pend_uc = 1'b1;
        if (wake.usb)
            f_d.pend_usb = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            f_q <= WKP_RESET;
        else
            f_q <= f_d;
    end

    assign fields = f_q;

    AST_PND_USB_SRC: assert property (@(posedge clk) disable iff (rst)
        $rose(f_q.pend_usb) |-> $past(halted && wake.usb)) else $error("pend_usb rose without wake"); // R5
    AST_PND_UC_SRC: assert property (@(posedge clk) disable iff (rst)
        $rose(f_q.pend_uc) |-> $past(halted && wake.uc)) else $error("pend_uc rose without wake"); // R5
    AST_HOS_IGNORED: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_data[B_HOS] && suspend && !f_q.halt_on_susp |=> !f_q.halt_on_susp) else $error("hos write accepted in suspend"); // R9
    AST_FH_IGNORED: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_data[B_FHALT] && attached && !f_q.force_halt |=> !f_q.force_halt) else $error("force halt accepted while attached"); // R10

endmodule

// File: rtl/wkp_halt.sv
module wkp_halt
    import wkp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        usb_evt,
    input  logic        uc_evt,
    input  logic        suspend,
    input  logic        fh_set,
    input  wkp_fields_t fields,
    output logic        halted,
    output wkp_src_t    wake
);

    logic halt_q;
    logic susp_q;
    logic susp_rise;
    logic enter;

    assign wake.usb  = halt_q & usb_evt & fields.en_usb;
    assign wake.uc   = halt_q & uc_evt & fields.en_uc;
    assign susp_rise = suspend & ~susp_q;
    assign enter     = fh_set | (fields.halt_on_susp & susp_rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            susp_q <= suspend;
            if (wake.usb || wake.uc)
                halt_q <= 1'b0;
            else if (enter)
                halt_q <= 1'b1;
        end
    end

    assign halted = halt_q;

    AST_SUSP_HALT: assert property (@(posedge clk) disable iff (rst)
        fields.halt_on_susp && suspend && !susp_q && !halt_q |=> halt_q) else $error("no halt on suspend"); // R8
    AST_IDLE_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        !halt_q |-> !(wake.usb || wake.uc)) else $error("wake while running"); // R5

endmodule

// File: rtl/wkp_delay.sv
module wkp_delay #(
    parameter int DELAY = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);

    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
        end else if (start) begin
            cnt_q  <= CW'(DELAY - 1);
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == '0)
                done_q <= 1'b1;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = done_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < DELAY) else $error("delay counter out of range"); // R7

endmodule

// File: rtl/wkp_ctrl.sv
module wkp_ctrl
    import wkp_pkg::*;
#(
    parameter int DELAY = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    input  logic             usb_evt,
    input  logic             uc_evt,
    input  logic             suspend,
    input  logic             attached,
    output logic             halted,
    output logic             wake_irq
);

    wkp_fields_t fields;
    wkp_src_t    wake;
    logic        fh_set;
    logic        dly_done;
    logic        pend_any;

    wkp_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .suspend  (suspend),
        .attached (attached),
        .wake     (wake),
        .halted   (halted),
        .fields   (fields),
        .fh_set   (fh_set)
    );

    wkp_halt u_halt (
        .clk      (clk),
        .rst      (rst),
        .usb_evt  (usb_evt),
        .uc_evt   (uc_evt),
        .suspend  (suspend),
        .fh_set   (fh_set),
        .fields   (fields),
        .halted   (halted),
        .wake     (wake)
    );

    wkp_delay #(.DELAY(DELAY)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .start (wake.usb | wake.uc),
        .done  (dly_done)
    );

    assign pend_any = fields.pend_usb | fields.pend_uc;
    assign wake_irq = pend_any & (~fields.delayed_irq | dly_done);
    assign rd_data  = rd_en ? wkp_pack(fields) : '0;

    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (rst)
        halted && ((usb_evt && fields.en_usb) || (uc_evt && fields.en_uc)) |=> !halted) else $error("wake did not end halt"); // R4
    AST_FH_ENTER: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_data[B_FHALT] && !attached && !halted |=> halted) else $error("force halt not taken"); // R10
    AST_DLY_QUIET: assert property (@(posedge clk) disable iff (rst)
        fields.delayed_irq && !dly_done |-> !wake_irq) else $error("irq inside delay window"); // R7
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[B_RSV] == 1'b0) else $error("reserved bit reads 1"); // R11

endmodule

// File: tb/wkp_ctrl_tb.sv
module wkp_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b1;
    logic [7:0] rd_data;
    logic       usb_evt = 1'b0;
    logic       uc_evt = 1'b0;
    logic       suspend = 1'b0;
    logic       attached = 1'b1;
    logic       halted;
    logic       wake_irq;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit m_fh, m_hos, m_mode, m_euc, m_eusb, m_puc, m_pusb, m_halt, m_sq;
    int m_wait;

    always #(CLK_PERIOD/2) clk = ~clk;

    wkp_ctrl #(.DELAY(DLY)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .usb_evt(usb_evt), .uc_evt(uc_evt),
        .suspend(suspend), .attached(attached), .halted(halted), .wake_irq(wake_irq)
    );

    function automatic logic [7:0] m_read();
        if (!rd_en) return 8'h00;
        return {m_fh, m_hos, m_mode, 1'b0, m_euc, m_eusb, m_puc, m_pusb};
    endfunction

    function automatic bit m_irq();
        return (m_pusb || m_puc) && (!m_mode || m_wait == 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_fh = 0; m_hos = 0; m_mode = 0; m_euc = 1; m_eusb = 1;
            m_puc = 1; m_pusb = 1; m_halt = 0; m_sq = 0; m_wait = 0;
        end else begin
            bit wu, wc, entry;
            wu    = m_halt && usb_evt && m_eusb;
            wc    = m_halt && uc_evt && m_euc;
            entry = (wr_en && wr_data[7] && !attached) || (m_hos && suspend && !m_sq);
            if (wu || wc) m_halt = 0;
            else if (entry) m_halt = 1;
            m_sq = suspend;
            if (wr_en) begin
                m_mode = wr_data[5];
                m_euc  = wr_data[3];
                m_eusb = wr_data[2];
                if (!(wr_data[6] && suspend)) m_hos = wr_data[6];
                if (!wr_data[7]) m_fh = 0;
                else if (!attached) m_fh = 1;
                if (!wr_data[1]) m_puc = 0;
                if (!wr_data[0]) m_pusb = 0;
            end
            if (wu || wc) m_fh = 0;
            if (wu) m_pusb = 1;
            if (wc) m_puc = 1;
            if (wu || wc) m_wait = DLY;
            else if (m_wait > 0) m_wait = m_wait - 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            checks += 3;
            if (halted !== m_halt) begin
                errors++;
                $display("FAIL R4 R8 R10 halted actual %0b expected %0b", halted, m_halt);
            end
            if (wake_irq !== m_irq()) begin
                errors++;
                $display("FAIL R6 R7 wake_irq actual %0b expected %0b", wake_irq, m_irq());
            end
            if (rd_data !== m_read()) begin
                errors++;
                $display("FAIL R2 R11 R12 rd_data actual %02h expected %02h", rd_data, m_read());
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_usb();
        usb_evt = 1'b1; tick(); usb_evt = 1'b0;
    endtask

    task automatic pulse_uc();
        uc_evt = 1'b1; tick(); uc_evt = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 reset image", rd_data, 8'h0F);
        chk("R1 reset halted", {7'd0, halted}, 8'h00);
        chk("R1 reset irq", {7'd0, wake_irq}, 8'h01);

        wr(8'hFF);                                  // attached: force-halt ignored
        chk("R11 R2 R10 write all ones", rd_data, 8'h6F);
        wr(8'h6C);
        chk("R2 pending cleared", rd_data, 8'h6C);
        chk("R2 irq after clear", {7'd0, wake_irq}, 8'h00);
        rd_en = 1'b0;
        tick();
        chk("R12 read strobe low", rd_data, 8'h00);
        rd_en = 1'b1;

        pulse_usb(); pulse_uc();
        tick();
        chk("R5 events while running", rd_data, 8'h6C);

        suspend = 1'b1;
        tick();
        chk("R8 halt on suspend", {7'd0, halted}, 8'h01);
        wr(8'h2C);
        wr(8'h6C);
        chk("R9 hos write ignored in suspend", rd_data, 8'h2C);

        usb_evt = 1'b1; tick(); usb_evt = 1'b0;
        chk("R4 wake ends halt", {7'd0, halted}, 8'h00);
        chk("R4 pending set", rd_data, 8'h2D);
        for (int i = 1; i < DLY; i++) begin
            chk("R7 irq held in window", {7'd0, wake_irq}, 8'h00);
            tick();
        end
        chk("R7 irq held last cycle", {7'd0, wake_irq}, 8'h00);
        tick();
        chk("R7 irq after delay", {7'd0, wake_irq}, 8'h01);

        suspend = 1'b0; attached = 1'b0;
        wr(8'hA4);
        chk("R10 force halt taken", {7'd0, halted}, 8'h01);
        chk("R10 force bit reads 1", rd_data, 8'hA4);
        pulse_uc();
        chk("R3 disabled source keeps halt", {7'd0, halted}, 8'h01);
        chk("R3 disabled source keeps pending", rd_data, 8'hA4);
        pulse_usb();
        chk("R13 wake clears force bit", rd_data, 8'h25);

        attached = 1'b1;
        wr(8'hA4);
        chk("R10 force ignored when attached", rd_data, 8'h24);
        chk("R10 no halt when attached", {7'd0, halted}, 8'h00);

        wr(8'h0C);
        attached = 1'b0;
        wr(8'h8C);
        chk("R10 halted for R6", {7'd0, halted}, 8'h01);
        pulse_uc();
        chk("R6 immediate irq", {7'd0, wake_irq}, 8'h01);
        chk("R6 processor pending", rd_data, 8'h0E);

        for (int i = 0; i < 600; i++) begin
            wr_en   = ($urandom % 5) == 0;
            wr_data = 8'($urandom);
            rd_en   = ($urandom % 4) != 0;
            usb_evt = ($urandom % 6) == 0;
            uc_evt  = ($urandom % 6) == 0;
            if (($urandom % 9) == 0) suspend = ~suspend;
            if (($urandom % 13) == 0) attached = ~attached;
            tick();
        end
        wr_en = 1'b0; usb_evt = 1'b0; uc_evt = 1'b0;
        tick();
        finish_run();
    end

endmodule